// File: doc/BRIEF.md
# GPIO Port with Interrupt Capture

A 32-pin general-purpose I/O port sitting behind a plain read/write register bus. Each pin has an output-data bit and a drive-enable bit. Software can load either register in one write. It can also touch single bits through set-only and clear-only alias addresses, so no read-modify-write is needed. Input pins are brought into the clock domain through a synchroniser, and software can read the synchronised values.

Every pin can raise an interrupt event. Three per-pin bits choose the sense: a level/edge select, a polarity bit and a both-edges bit. Detected events latch into a sticky capture register, and software clears that register by writing ones. A per-pin enable, with its own set and clear aliases, decides which captured bits drive the single registered interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: Register decode by byte address: 0x00 output data, 0x04 input data (read only), 0x08 drive enable, 0x18 sense polarity, 0x1C both-edges select, 0x20 capture, 0x2C level select, 0x30 enable-set, 0x34 enable-clear, 0x40 output-set, 0x44 output-clear, 0x48 drive-set, 0x4C drive-clear. Each alias reads back the register it modifies. Any other address reads zero. Read data is registered and shows the addressed register one cycle after the address is presented.
- R2: A write to 0x00 loads the output register. A write to 0x40 ORs the data into it, and a write to 0x44 clears the bits written as 1. `pin_out` shows the register one cycle after the write.
- R3: The drive-enable register behaves the same way through 0x08, 0x48 and 0x4C. A 1 drives the pin, and `pin_oe` shows the register.
- R4: Reading 0x04 returns the pin values after a two-flop synchroniser.
- R5: When a pin's level-select bit is 0 and its both-edges bit is 0, the pin captures a rising edge if its polarity bit is 0 and a falling edge if its polarity bit is 1. An edge is a change between consecutive synchronised samples.
- R6: When a pin's level-select bit is 0 and its both-edges bit is 1, the pin captures both rising and falling edges.
- R7: When a pin's level-select bit is 1, the pin captures on every cycle its active level is present: high if its polarity bit is 0, low if it is 1. Clearing the capture bit takes effect only once the level is inactive.
- R8: Writing 1 to a capture bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins. Capture bits never fall without a clear.
- R9: Writing ones to 0x30 sets enable bits, and writing ones to 0x34 clears them. Zero bits have no effect.
- R10: `irq` is a register loaded with the OR over all pins of capture AND enable. It rises one cycle after an enabled capture bit sets.
- R11: Synchronous active-high reset zeroes every register, `pin_out`, `pin_oe`, `irq` and the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Summary interrupt |

## Verification
The bench aims at these cases:
- A capture clear in the same cycle as an active level. A design that let the clear win would drop a level interrupt that is still asserted.
- Capture bits that are not written while other bits are cleared. A design that wrote the whole register would lose pending events.
- Both-edges pins and falling-polarity pins. A swapped encoding would capture on the wrong edge or miss one edge.
- Set and clear aliases hit with mixed masks. An alias that wrote through would destroy the neighbouring bits.

A random phase drives all thirteen addresses and toggles pins freely, against a behavioural model compared on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_OUT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_IN     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DRV    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_BOTH   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CAP    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_LVL    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_ENSET  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ENCLR  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_OUTSET = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_OUTCLR = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_DRVSET = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_DRVCLR = 8'h4C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[DEPTH-2:0], d};
  end

  assign q      = pipe[STAGES-1];
  assign q_prev = pipe[STAGES];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  output logic [W-1:0] evt
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    always_comb begin
      rise     = cur[i] & ~prev[i];
      fall     = ~cur[i] & prev[i];
      lvl_hit  = pol[i] ? ~cur[i] : cur[i];
      if (both[i])     edge_hit = rise | fall;
      else if (pol[i]) edge_hit = fall;
      else             edge_hit = rise;
      evt[i] = lvl_sel[i] ? lvl_hit : edge_hit;
    end
  end
endmodule

// File: rtl/gpio_bitreg.sv
module gpio_bitreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_load,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (wr_load) q <= wdata;
    else if (wr_set)  q <= q | wdata;
    else if (wr_clr)  q <= q & ~wdata;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] in_sync, in_prev, evt;
  logic [NPINS-1:0] out_q, drv_q, en_q;
  logic [NPINS-1:0] pol_q, both_q, lvl_q, cap_q;

  function automatic logic hit(input logic [ADDR_W-1:0] off);
    return bus_wr && (bus_addr == off);
  endfunction

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(in_sync), .q_prev(in_prev)
  );

  gpio_evt_detect #(.W(NPINS)) u_det (
    .cur(in_sync), .prev(in_prev), .lvl_sel(lvl_q), .pol(pol_q),
    .both(both_q), .evt(evt)
  );

  gpio_bitreg #(.W(NPINS)) u_out (
    .clk(clk), .rst(rst), .wr_load(hit(OFF_OUT)), .wr_set(hit(OFF_OUTSET)),
    .wr_clr(hit(OFF_OUTCLR)), .wdata(bus_wdata), .q(out_q)
  );

  gpio_bitreg #(.W(NPINS)) u_drv (
    .clk(clk), .rst(rst), .wr_load(hit(OFF_DRV)), .wr_set(hit(OFF_DRVSET)),
    .wr_clr(hit(OFF_DRVCLR)), .wdata(bus_wdata), .q(drv_q)
  );

  gpio_bitreg #(.W(NPINS)) u_en (
    .clk(clk), .rst(rst), .wr_load(1'b0), .wr_set(hit(OFF_ENSET)),
    .wr_clr(hit(OFF_ENCLR)), .wdata(bus_wdata), .q(en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      both_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (hit(OFF_POL))  pol_q  <= bus_wdata;
      if (hit(OFF_BOTH)) both_q <= bus_wdata;
      if (hit(OFF_LVL))  lvl_q  <= bus_wdata;
    end
  end

  // sticky capture: clear-by-one, new event takes priority
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= (cap_q & ~(hit(OFF_CAP) ? bus_wdata : '0)) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(cap_q & en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        OFF_OUT, OFF_OUTSET, OFF_OUTCLR: bus_rdata <= out_q;
        OFF_DRV, OFF_DRVSET, OFF_DRVCLR: bus_rdata <= drv_q;
        OFF_ENSET, OFF_ENCLR:            bus_rdata <= en_q;
        OFF_IN:                          bus_rdata <= in_sync;
        OFF_POL:                         bus_rdata <= pol_q;
        OFF_BOTH:                        bus_rdata <= both_q;
        OFF_CAP:                         bus_rdata <= cap_q;
        OFF_LVL:                         bus_rdata <= lvl_q;
        default:                         bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = drv_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic              irq,
  input logic [W-1:0]      cap_q,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      evt
);
  AST_OUT_SET_ORS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_OUTSET) |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R2
  AST_OUT_CLR_MASKS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_OUTCLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R2
  AST_DRV_SET_ORS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_DRVSET) |=> pin_oe == ($past(pin_oe) | $past(bus_wdata))); // R3
  AST_CAP_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_CAP) |=> (cap_q & $past(bus_wdata) & ~$past(evt)) == '0); // R8
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFF_CAP) |=> ($past(cap_q) & ~cap_q) == '0); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq); // R10
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && !irq)); // R11
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(NPINS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .cap_q(cap_q), .en_q(en_q), .evt(evt)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_out, m_drv, m_pol, m_both, m_lvl, m_cap, m_en, m_rd;
  logic [31:0] m_s1, m_s2, m_prev;
  logic        m_irq;

  always @(posedge clk) begin
    logic [31:0] ev, nrd;
    logic        nirq;
    if (rst) begin
      m_out = 0; m_drv = 0; m_pol = 0; m_both = 0; m_lvl = 0; m_cap = 0;
      m_en = 0; m_rd = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0;
    end else begin
      case (bus_addr)
        8'h00, 8'h40, 8'h44: nrd = m_out;
        8'h08, 8'h48, 8'h4C: nrd = m_drv;
        8'h30, 8'h34:        nrd = m_en;
        8'h04: nrd = m_s2;
        8'h18: nrd = m_pol;
        8'h1C: nrd = m_both;
        8'h20: nrd = m_cap;
        8'h2C: nrd = m_lvl;
        default: nrd = 0;
      endcase
      ev = 0;
      for (int i = 0; i < 32; i++) begin
        bit c, p;
        c = m_s2[i]; p = m_prev[i];
        if (m_lvl[i]) ev[i] = m_pol[i] ? !c : c;
        else if (m_both[i]) ev[i] = (c != p);
        else if (m_pol[i]) ev[i] = !c && p;
        else ev[i] = c && !p;
      end
      nirq = (m_cap & m_en) != 0;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_out = bus_wdata;
          8'h40: m_out = m_out | bus_wdata;
          8'h44: m_out = m_out & ~bus_wdata;
          8'h08: m_drv = bus_wdata;
          8'h48: m_drv = m_drv | bus_wdata;
          8'h4C: m_drv = m_drv & ~bus_wdata;
          8'h18: m_pol = bus_wdata;
          8'h1C: m_both = bus_wdata;
          8'h2C: m_lvl = bus_wdata;
          8'h30: m_en = m_en | bus_wdata;
          8'h34: m_en = m_en & ~bus_wdata;
          8'h20: m_cap = m_cap & ~bus_wdata;
          default: ;
        endcase
      end
      m_cap = m_cap | ev;
      m_irq = nirq;
      m_rd = nrd;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 pin_out", pin_out, m_out);
      check("R3 pin_oe", pin_oe, m_drv);
      check("R10 irq", {31'b0, irq}, {31'b0, m_irq});
      check("R1 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a;
    @(negedge clk); check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    report();
  end

  localparam logic [7:0] ADDRS [14] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C,
    8'h20, 8'h2C, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h10};

  initial begin
    idle(4);
    rst = 0;
    // R11: reset state
    rd_chk(8'h00, 32'h0, "R11 out after reset");
    check("R11 irq after reset", {31'b0, irq}, 32'h0);
    check("R11 pin_oe after reset", pin_oe, 32'h0);
    // R2: direct load and aliases
    wr(8'h00, 32'hF0); wr(8'h40, 32'h0F);
    rd_chk(8'h00, 32'hFF, "R2 output set alias");
    wr(8'h44, 32'h30);
    rd_chk(8'h44, 32'hCF, "R2 output clear alias");
    check("R2 pin_out", pin_out, 32'hCF);
    // R3: drive enable
    wr(8'h08, 32'h0); wr(8'h48, 32'h3); wr(8'h4C, 32'h1);
    check("R3 pin_oe after set/clear", pin_oe, 32'h2);
    // R4: synchronised input
    pin_in = 32'hA5A5A5A5; idle(3);
    rd_chk(8'h04, 32'hA5A5A5A5, "R4 input read");
    pin_in = 0; idle(3);
    wr(8'h20, 32'hFFFFFFFF);
    rd_chk(8'h20, 32'h0, "R8 capture cleared by ones");
    rd_chk(8'h10, 32'h0, "R1 unmapped reads zero");
    // R5/R6: edge modes
    wr(8'h18, 32'h2); wr(8'h1C, 32'h4); wr(8'h30, 32'hF);
    rd_chk(8'h34, 32'hF, "R9 enable read via clear alias");
    pin_in = 32'h7; idle(4);
    rd_chk(8'h20, 32'h5, "R5 R6 rising captures");
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    pin_in = 0; idle(4);
    rd_chk(8'h20, 32'h7, "R5 R6 falling captures");
    wr(8'h20, 32'h0);
    rd_chk(8'h20, 32'h7, "R8 zero write keeps capture");
    wr(8'h20, 32'h7); idle(2);
    check("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    // R7: level mode
    wr(8'h2C, 32'h8);
    pin_in = 32'h8; idle(4);
    wr(8'h20, 32'h8);
    rd_chk(8'h20, 32'h8, "R7 level recaptures over clear");
    pin_in = 0; idle(4);
    wr(8'h20, 32'h8);
    rd_chk(8'h20, 32'h0, "R7 clear after level inactive");
    // R9: enable clear masks irq
    wr(8'h34, 32'hF);
    rd_chk(8'h30, 32'h0, "R9 enables cleared");
    wr(8'h2C, 32'h0);
    pin_in = 32'h1; idle(4);
    check("R10 masked capture gives no irq", {31'b0, irq}, 32'h0);
    rd_chk(8'h20, 32'h1, "R8 capture latches while disabled");
    // random phase, scoreboard checks every cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      bus_wr = ($urandom_range(0, 2) == 0);
      bus_addr = ADDRS[$urandom_range(0, 13)];
      bus_wdata = $urandom();
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 40) == 0) pin_in = $urandom();
    end
    @(negedge clk); bus_wr = 0;
    idle(4);
    done = 1;
    report();
  end
endmodule